// File: doc/BRIEF.md
# Clock-to-Sample-Rate Ratio Detector

This block watches a word-select (frame) signal from the system-clock domain. It measures how many system-clock cycles each word-select period spans, and it reports which of six oversampling ratios the system clock runs at: 128, 192, 256, 384, 512 or 768 times the sample rate. The system clock is frequency-locked to word-select, so a stable stream gives the same integer count every period. No pin or register selects the clock mode. The block finds it by itself and keeps tracking when the sample rate changes, for example when one fixed system clock is reused at a new sample rate.

Each period is measured from one rising edge of word-select to the next. The count is compared against every nominal ratio with a small tolerance window. A hysteresis stage publishes a mode only after several consecutive periods agree, and it withdraws the mode only after repeated disagreement. A count that matches no ratio is reported at once as an error. A word-select that stops toggling is also reported as an error, because the period counter saturates.

Top module: `fsr_ratio_detect`

## Requirements
- R1: After reset, mode_o is 7 (unknown), locked_o is 0 and err_o is 0.
- R2: A measurement is the number of clk_i cycles between two consecutive rising edges of ws_i. The first rising edge after reset only starts the count and changes no output.
- R3: A measurement within ±2 cycles of a nominal ratio is classified with the codes 0=128, 1=192, 2=256, 3=384, 4=512 and 5=768, at both tolerance limits.
- R4: A measurement that is 3 or more cycles away from every nominal ratio sets err_o to 1, locked_o to 0 and mode_o to 7 with that same measurement, whatever the prior state.
- R5: locked_o rises, and mode_o shows the code, on the third consecutive measurement that gives the same code. Two such measurements are not enough.
- R6: While locked, a single in-range measurement of a different code leaves mode_o and locked_o unchanged, and the next matching measurement clears the disagreement.
- R7: While locked, two consecutive measurements that disagree with the reported code drop locked_o and set mode_o to 7. mode_o never steps directly from one valid code to another.
- R8: err_o returns to 0 on the next in-range measurement after an error.
- R9: The period counter is 11 bits wide and saturates. If ws_i gives no rising edge for 2047 cycles, err_o is set, locked_o is cleared and mode_o becomes 7, without waiting for an edge.
- R10: Outputs change only in the cycle after a measurement or a stall event. While locked_o is 1, err_o is 0 and mode_o is below 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ws_i | input | 1 | Word-select signal, one period per sample frame |
| mode_o | output | 3 | Detected ratio code (0..5), 7 when unknown |
| locked_o | output | 1 | The reported mode is confirmed by hysteresis |
| err_o | output | 1 | The last measurement was out of range, or word-select stalled |

## Verification
The counter's saturation (stall) event and a word-select rising edge can both arrive in the same cycle. The first one opens the error path, the second closes a measurement. The bench provokes this with periods of 2046, 2047 and 2048 cycles, which put the edge just before, exactly on, and just after the cycle in which the counter reaches its limit. In every case the expected result is err_o high and locked_o low. After that, in-range periods must clear the error on the first measurement and relock on exactly the third, which shows that the coinciding events left no stale candidate or disagreement count behind.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

   localparam int NUM_MODES = 6;

   typedef enum logic [2:0] {
      MODE_X128  = 3'd0,
      MODE_X192  = 3'd1,
      MODE_X256  = 3'd2,
      MODE_X384  = 3'd3,
      MODE_X512  = 3'd4,
      MODE_X768  = 3'd5,
      MODE_NONE  = 3'd7
   } fsr_mode_e;

   // Nominal clocks per frame for each mode code.
   function automatic int nominal_ratio(input int idx);
      case (idx)
         0:       return 128;
         1:       return 192;
         2:       return 256;
         3:       return 384;
         4:       return 512;
         default: return 768;
      endcase
   endfunction

endpackage

// File: rtl/fsr_edge.sv
module fsr_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ws_i,
   output logic rise_o
);

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("fsr_edge: SYNC_STAGES must be 0..4");
   end

   logic ws_s;
   logic ws_prev_q;

   if (SYNC_STAGES == 0) begin : g_direct
      assign ws_s = ws_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sh_q <= '0;
         else         sh_q <= SYNC_STAGES'({sh_q, ws_i});
      end
      assign ws_s = sh_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ws_prev_q <= 1'b0;
      else         ws_prev_q <= ws_s;
   end

   assign rise_o = ws_s & ~ws_prev_q;

endmodule

// File: rtl/fsr_period.sv
module fsr_period #(
   parameter int CNT_W = 11
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rise_i,
   output logic [CNT_W-1:0] meas_o,
   output logic             meas_vld_o,
   output logic             stall_o
);

   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_NEAR = CNT_MAX - 1'b1;

   logic [CNT_W-1:0] cnt_q;
   logic             primed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q      <= '0;
         primed_q   <= 1'b0;
         meas_o     <= '0;
         meas_vld_o <= 1'b0;
         stall_o    <= 1'b0;
      end else begin
         stall_o <= !rise_i && (cnt_q == CNT_NEAR);
         if (rise_i) begin
            cnt_q      <= CNT_W'(1);
            primed_q   <= 1'b1;
            meas_vld_o <= primed_q;
            if (primed_q) meas_o <= cnt_q;
         end else begin
            meas_vld_o <= 1'b0;
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/fsr_classify.sv
module fsr_classify
   import fsr_pkg::*;
#(
   parameter int CNT_W = 11,
   parameter int TOL   = 2
) (
   input  logic [CNT_W-1:0] meas_i,
   output fsr_mode_e        mode_o,
   output logic             hit_o
);

   logic [NUM_MODES-1:0] hit;

   for (genvar g = 0; g < NUM_MODES; g++) begin : g_win
      localparam logic [CNT_W-1:0] LO = CNT_W'(nominal_ratio(g) - TOL);
      localparam logic [CNT_W-1:0] HI = CNT_W'(nominal_ratio(g) + TOL);
      assign hit[g] = (meas_i >= LO) && (meas_i <= HI);
   end

   always_comb begin
      hit_o  = 1'b0;
      mode_o = MODE_NONE;
      for (int i = NUM_MODES - 1; i >= 0; i--) begin
         if (hit[i]) begin
            hit_o  = 1'b1;
            mode_o = fsr_mode_e'(3'(i));
         end
      end
   end

endmodule

// File: rtl/fsr_hyst.sv
module fsr_hyst
   import fsr_pkg::*;
#(
   parameter int LOCK_N   = 3,
   parameter int UNLOCK_N = 2
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      meas_vld_i,
   input  logic      stall_i,
   input  fsr_mode_e cls_i,
   input  logic      hit_i,
   output fsr_mode_e mode_o,
   output logic      locked_o,
   output logic      err_o
);

   localparam int RUN_W  = $clog2(LOCK_N + 1);
   localparam int MISS_W = $clog2(UNLOCK_N + 1);
   localparam logic [RUN_W-1:0]  RUN_LIM  = RUN_W'(LOCK_N);
   localparam logic [MISS_W-1:0] MISS_LIM = MISS_W'(UNLOCK_N);

   fsr_mode_e         cand_q;
   logic [RUN_W-1:0]  run_q, run_nx;
   logic [MISS_W-1:0] miss_q, miss_nx;
   logic              bad;

   assign bad     = stall_i || (meas_vld_i && !hit_i);
   assign miss_nx = miss_q + 1'b1;

   always_comb begin
      if (cls_i != cand_q)     run_nx = RUN_W'(1);
      else if (run_q == RUN_LIM) run_nx = run_q;
      else                     run_nx = run_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cand_q   <= MODE_NONE;
         run_q    <= '0;
         miss_q   <= '0;
         mode_o   <= MODE_NONE;
         locked_o <= 1'b0;
         err_o    <= 1'b0;
      end else if (bad) begin
         cand_q   <= MODE_NONE;
         run_q    <= '0;
         miss_q   <= '0;
         mode_o   <= MODE_NONE;
         locked_o <= 1'b0;
         err_o    <= 1'b1;
      end else if (meas_vld_i) begin
         err_o  <= 1'b0;
         cand_q <= cls_i;
         run_q  <= run_nx;
         if (locked_o) begin
            if (cls_i == mode_o) begin
               miss_q <= '0;
            end else if (miss_nx == MISS_LIM) begin
               miss_q   <= '0;
               locked_o <= 1'b0;
               mode_o   <= MODE_NONE;
            end else begin
               miss_q <= miss_nx;
            end
         end else if (run_nx >= RUN_LIM) begin
            locked_o <= 1'b1;
            mode_o   <= cls_i;
            miss_q   <= '0;
         end
      end
   end

endmodule

// File: rtl/fsr_ratio_detect.sv
module fsr_ratio_detect
   import fsr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 11,
   parameter int TOL         = 2,
   parameter int LOCK_N      = 3,
   parameter int UNLOCK_N    = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       ws_i,
   output logic [2:0] mode_o,
   output logic       locked_o,
   output logic       err_o
);

   localparam int TOP_NOM = 768;

   if (CNT_W < 10 || CNT_W > 16) begin : g_bad_cnt
      $error("fsr_ratio_detect: CNT_W must be 10..16");
   end
   if (TOL < 0 || TOL > 31) begin : g_bad_tol
      $error("fsr_ratio_detect: TOL must keep windows disjoint");
   end
   if ((TOP_NOM + TOL) >= ((1 << CNT_W) - 1)) begin : g_bad_range
      $error("fsr_ratio_detect: counter too narrow for largest ratio");
   end
   if (LOCK_N < 1 || UNLOCK_N < 1) begin : g_bad_hyst
      $error("fsr_ratio_detect: hysteresis counts must be positive");
   end

   logic             rise;
   logic [CNT_W-1:0] meas;
   logic             meas_vld;
   logic             stall_evt;
   fsr_mode_e        cls_mode;
   logic             cls_hit;
   fsr_mode_e        mode_e;

   fsr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ws_i   (ws_i),
      .rise_o (rise)
   );

   fsr_period #(.CNT_W(CNT_W)) u_period (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rise_i     (rise),
      .meas_o     (meas),
      .meas_vld_o (meas_vld),
      .stall_o    (stall_evt)
   );

   fsr_classify #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
      .meas_i (meas),
      .mode_o (cls_mode),
      .hit_o  (cls_hit)
   );

   fsr_hyst #(.LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) u_hyst (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .meas_vld_i (meas_vld),
      .stall_i    (stall_evt),
      .cls_i      (cls_mode),
      .hit_i      (cls_hit),
      .mode_o     (mode_e),
      .locked_o   (locked_o),
      .err_o      (err_o)
   );

   assign mode_o = mode_e;

endmodule

// File: rtl/fsr_ratio_detect_chk.sv
module fsr_ratio_detect_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [2:0] mode_o,
   input logic       locked_o,
   input logic       err_o,
   input logic       meas_vld,
   input logic       stall_evt,
   input logic       cls_hit
);

   // R10
   locked_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked_o |-> (!err_o && mode_o != 3'd7));

   // R7
   unlocked_unknown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !locked_o |-> (mode_o == 3'd7));

   // R7
   no_direct_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (locked_o && $past(locked_o)) |-> $stable(mode_o));

   // R10
   quiet_between_events_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(meas_vld || stall_evt) |-> $stable({mode_o, locked_o, err_o}));

   // R5
   lock_on_measure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(locked_o) |-> $past(meas_vld && cls_hit));

   // R4
   err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o) |-> $past(stall_evt || (meas_vld && !cls_hit)));

   // R8
   err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(err_o) |-> $past(meas_vld && cls_hit && !stall_evt));

endmodule

bind fsr_ratio_detect fsr_ratio_detect_chk u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .mode_o    (mode_o),
   .locked_o  (locked_o),
   .err_o     (err_o),
   .meas_vld  (meas_vld),
   .stall_evt (stall_evt),
   .cls_hit   (cls_hit)
);

// File: tb/fsr_ratio_detect_tb.sv
module fsr_ratio_detect_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ws = 1'b0;
   logic [2:0] mode;
   logic       locked;
   logic       err;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   // Bench model of the requirements
   int  m_mode = 7;
   bit  m_lock = 0;
   bit  m_err  = 0;
   int  m_cand = 7;
   int  m_run  = 0;
   int  m_miss = 0;
   bit  primed = 0;
   int  prev_len = 0;

   always #10 clk = ~clk;

   fsr_ratio_detect u_dut (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .ws_i     (ws),
      .mode_o   (mode),
      .locked_o (locked),
      .err_o    (err)
   );

   function automatic int nom_of(input int i);
      case (i)
         0: return 128; 1: return 192; 2: return 256;
         3: return 384; 4: return 512; default: return 768;
      endcase
   endfunction

   // R3: +-2 window around each nominal, codes 0..5, otherwise 7
   function automatic int classify(input int n);
      for (int i = 0; i < 6; i++)
         if (n >= nom_of(i) - 2 && n <= nom_of(i) + 2) return i;
      return 7;
   endfunction

   task automatic model_bad();
      m_err = 1; m_lock = 0; m_mode = 7; m_cand = 7; m_run = 0; m_miss = 0;
   endtask

   task automatic model_meas(input int n);
      int c;
      c = classify(n);
      if (c == 7) begin
         model_bad();
      end else begin
         m_err = 0;
         m_run = (c == m_cand) ? ((m_run < 3) ? m_run + 1 : 3) : 1;
         m_cand = c;
         if (m_lock) begin
            if (c == m_mode) m_miss = 0;
            else if (m_miss + 1 == 2) begin
               m_miss = 0; m_lock = 0; m_mode = 7;
            end else m_miss = m_miss + 1;
         end else if (m_run >= 3) begin
            m_lock = 1; m_mode = c; m_miss = 0;
         end
      end
   endtask

   task automatic compare(input string tag);
      n_vec++;
      if (mode !== 3'(m_mode) || locked !== m_lock || err !== m_err) begin
         n_bad++;
         $display("FAIL %s: got mode=%0d locked=%0b err=%0b expected mode=%0d locked=%0b err=%0b",
                  tag, mode, locked, err, m_mode, m_lock, m_err);
      end
   endtask

   // One word-select period of n clocks, rising edge first; check 20 cycles after the edge.
   task automatic period(input int n, input string tag);
      ws = 1'b1;
      repeat (20) @(negedge clk);
      if (primed) model_meas(prev_len);
      primed = 1;
      compare(tag);
      repeat (n / 2 - 20) @(negedge clk);
      ws = 1'b0;
      repeat (n - n / 2) @(negedge clk);
      prev_len = n;
      if (n >= 2100) begin
         model_bad();
         compare(tag);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R2 watchdog: got hang expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int md, rl, jt, ln;
      void'($urandom(32'h1a2b));
      repeat (5) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      compare("R1");

      // R2: first edge only primes; R5: lock on third matching period
      period(256, "R2");
      period(256, "R5");
      period(256, "R5");
      period(256, "R5");
      period(256, "R5");

      // R3: both tolerance limits and centre of every ratio
      for (int i = 0; i < 6; i++) begin
         period(nom_of(i) - 2, "R3");
         period(nom_of(i) + 2, "R3");
         period(nom_of(i),     "R3");
         period(nom_of(i) - 1, "R7");
         period(nom_of(i) + 1, "R7");
      end

      // R6: one disagreeing period while locked is ignored
      period(384, "R6"); period(384, "R6"); period(384, "R6"); period(384, "R6");
      period(512, "R6"); period(384, "R6"); period(512, "R6"); period(384, "R6");

      // R7: two disagreeing periods unlock, third relocks
      period(128, "R7"); period(128, "R7"); period(128, "R7"); period(128, "R7");

      // R4 / R8: just outside windows, then recovery
      period(131, "R4"); period(125, "R4"); period(253, "R4");
      period(192, "R8"); period(192, "R8"); period(192, "R8"); period(192, "R8");
      period(771, "R4"); period(765, "R4"); period(768, "R8");
      period(768, "R8"); period(768, "R8");

      // R9: stall and the saturation/edge coincidence
      period(2200, "R9");
      period(2046, "R9"); period(2047, "R9"); period(2048, "R9");
      period(256, "R8"); period(256, "R8"); period(256, "R5"); period(256, "R5");
      period(256, "R5");

      // Random mix: runs of one ratio with occasional jitter
      for (int k = 0; k < 60; k++) begin
         md = $urandom % 6;
         rl = 1 + ($urandom % 4);
         for (int j = 0; j < rl; j++) begin
            jt = ($urandom % 8 < 6) ? 0 : (int'($urandom % 9) - 4);
            ln = nom_of(md) + jt;
            period(ln, (classify(ln) == 7) ? "R4" : "R3");
         end
      end
      period(256, "R10");

      done = 1;
      summary();
      $finish;
   end

endmodule